// File: doc/BRIEF.md
# Rechargeable Cell Charge Sequencer

This block steps a NiCd or NiMH charger through the phases of one charge cycle: pending, fast charge, an optional top-off, pulse-trickle and low-power. It works only from digital inputs. Synchronized comparator flags report where the battery voltage and the temperature sense voltage sit relative to their thresholds. A two-bit code carries the decoded three-level timer-mode selection. There is also an inhibit input, a termination event from the voltage-slope detector, and a 1 ms tick.

The block drives a phase code for the charge-output modulator and an enable for the open-drain status LED. It also flags the voltage hold-off window, requests a reset of the slope detector's sample history when fast charge begins, and tells the detector which slope test to apply. A cause code records why the last charging phase ended. The mode code picks the safety-time limit, the hold-off length, the slope test and whether top-off follows. Its value is captured when fast charge begins. Time is counted in seconds from the tick through a prescaler, so the limits scale with parameters.

Top module: `charge_seq`

## Requirements
- R1: While reset is held, phase_o is 0 (pending) and led_en_o, holdoff_o, det_rst_o and term_o are 0. The first clock edge after reset evaluates the start conditions with no start delay.
- R2: From pending, fast charge (phase 1) begins only when vbat_lo_i, vbat_hi_i and temp_hot_i are all 0. Otherwise the phase becomes pulse-trickle (3).
- R3: Outside low-power, a 1-to-0 transition of vbat_hi_i counts as a battery insertion. It moves the phase to pending and clears term_o. The start conditions are evaluated once START_DLY_TICKS ticks have elapsed.
- R4: Mode codes: 0 selects an 80 min limit, 150 s hold-off, the peak test and top-off. 1 and 3 select 200 min (160 min when ALT_MID_LIMIT is 1), 300 s hold-off, the peak test and no top-off. 2 selects 40 min, 75 s hold-off, the negative-delta test (slope_neg_o = 1) and no top-off. The mode is captured when fast charge begins.
- R5: When fast charge ends, term_o reports the highest-priority cause present: temperature cutoff (1), then maximum voltage (2), then slope event (3), then timer expiry (4).
- R6: holdoff_o is 1 in fast charge while elapsed seconds are below the hold-off length. A slope event in that window is ignored, while the temperature and maximum-voltage terminations still act.
- R7: A fast charge ended by a slope event or by timer expiry in mode 0 continues in top-off (2). Any other end goes to pulse-trickle. Top-off ends on temperature cutoff, maximum voltage or timer expiry only.
- R8: led_en_o is 1 only in fast charge. det_rst_o is a one-cycle pulse in the first cycle of fast charge.
- R9: While inhibit_i is 1, the fast-charge or top-off phase and its timer hold their values. A temperature cutoff still ends the phase, and the timer resumes from its held value on release.
- R10: The timer advances once per TICKS_PER_SEC ticks and is cleared on entry to fast charge and to top-off. When elapsed seconds reach minutes × SEC_PER_MIN, the phase ends on the next edge. Pulse-trickle has no limit.
- R11: vbat_pd_i = 1 moves any phase to low-power (4) on the next edge, with led_en_o at 0. When vbat_pd_i returns to 0, the phase becomes pulse-trickle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_ms_i | input | 1 | One-cycle pulse every millisecond |
| vbat_lo_i | input | 1 | Battery voltage below minimum-cell threshold |
| vbat_hi_i | input | 1 | Battery voltage at or above maximum-cell threshold |
| vbat_pd_i | input | 1 | Battery voltage above power-down threshold |
| temp_hot_i | input | 1 | Temperature sense below high-temperature-fault threshold |
| temp_cut_i | input | 1 | Temperature sense below cutoff threshold |
| mode_i | input | 2 | Decoded timer mode: 0 low, 1 mid, 2 high, 3 as mid |
| inhibit_i | input | 1 | Suspend fast charge and top-off |
| vterm_i | input | 1 | Slope-detector termination event |
| phase_o | output | 3 | 0 pending, 1 fast, 2 top-off, 3 trickle, 4 low-power |
| led_en_o | output | 1 | Pull status LED low |
| holdoff_o | output | 1 | Slope hold-off window active |
| det_rst_o | output | 1 | Clear slope-detector history |
| slope_neg_o | output | 1 | 1 selects negative-delta test, 0 peak test |
| term_o | output | 3 | Last cause: 0 none, 1 temperature, 2 max voltage, 3 slope, 4 timer |

## Verification
A flag change moves phase_o and term_o on the first rising edge after it. Fast charge begins on the first edge after reset is released, and holdoff_o falls H edges after that entry. The timer ends a phase L+1 edges after entry, and each edge spent under inhibit pushes that out by one. After an insertion, fast charge starts START_DLY_TICKS+2 edges after the flag falls. The bench drives inputs and samples outputs on falling edges, waiting exactly those counts, and it checks the edge before each transition as well as the transition itself.

// File: rtl/charge_seq_pkg.sv
package charge_seq_pkg;
  typedef enum logic [2:0] {
    PH_PEND    = 3'd0,
    PH_FAST    = 3'd1,
    PH_TOP     = 3'd2,
    PH_TRICKLE = 3'd3,
    PH_LOWPWR  = 3'd4
  } phase_e;

  typedef enum logic [2:0] {
    CAUSE_NONE  = 3'd0,
    CAUSE_TEMP  = 3'd1,
    CAUSE_VMAX  = 3'd2,
    CAUSE_SLOPE = 3'd3,
    CAUSE_TIME  = 3'd4
  } cause_e;

  localparam logic [1:0] MODE_LOW  = 2'd0;
  localparam logic [1:0] MODE_MID  = 2'd1;
  localparam logic [1:0] MODE_HIGH = 2'd2;
endpackage

// File: rtl/charge_seq_sec_timer.sv
module charge_seq_sec_timer #(
  parameter int TICKS_PER_SEC = 1000,
  parameter int TW            = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          run_i,
  input  logic          clr_i,
  output logic [TW-1:0] elapsed_o
);
  localparam int PW = (TICKS_PER_SEC > 1) ? $clog2(TICKS_PER_SEC) : 1;
  localparam logic [PW-1:0] PRE_LAST = PW'(TICKS_PER_SEC - 1);

  logic [PW-1:0] pre_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_q     <= '0;
      elapsed_o <= '0;
    end else if (clr_i) begin
      pre_q     <= '0;
      elapsed_o <= '0;
    end else if (run_i && tick_i) begin
      if (pre_q == PRE_LAST) begin
        pre_q <= '0;
        if (elapsed_o != '1) elapsed_o <= elapsed_o + 1'b1;
      end else begin
        pre_q <= pre_q + 1'b1;
      end
    end
  end

  // R10: cleared timer starts from zero
  assert_clr_zero_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (elapsed_o == '0));
  // R9: a stopped timer holds its value
  assert_hold_when_stopped_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_i && !clr_i) |=> $stable(elapsed_o));
endmodule

// File: rtl/charge_seq_mode_cfg.sv
module charge_seq_mode_cfg
  import charge_seq_pkg::*;
#(
  parameter int SEC_PER_MIN   = 60,
  parameter int ALT_MID_LIMIT = 0,
  parameter int TW            = 16
) (
  input  logic [1:0]    mode_i,
  output logic [TW-1:0] limit_o,
  output logic [TW-1:0] holdoff_o,
  output logic          topoff_en_o,
  output logic          slope_neg_o
);
  localparam logic [TW-1:0] LIM_LOW  = TW'(80 * SEC_PER_MIN);
  localparam logic [TW-1:0] LIM_HIGH = TW'(40 * SEC_PER_MIN);

  logic [TW-1:0] lim_mid;

  generate
    if (ALT_MID_LIMIT != 0) begin : g_mid_short
      assign lim_mid = TW'(160 * SEC_PER_MIN);
    end else begin : g_mid_long
      assign lim_mid = TW'(200 * SEC_PER_MIN);
    end
  endgenerate

  always_comb begin
    unique case (mode_i)
      MODE_LOW: begin
        limit_o = LIM_LOW;  holdoff_o = TW'(150); topoff_en_o = 1'b1; slope_neg_o = 1'b0;
      end
      MODE_HIGH: begin
        limit_o = LIM_HIGH; holdoff_o = TW'(75);  topoff_en_o = 1'b0; slope_neg_o = 1'b1;
      end
      default: begin
        limit_o = lim_mid;  holdoff_o = TW'(300); topoff_en_o = 1'b0; slope_neg_o = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/charge_seq_fsm.sv
module charge_seq_fsm
  import charge_seq_pkg::*;
#(
  parameter int START_DLY_TICKS = 500,
  parameter int TW              = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          vbat_lo_i,
  input  logic          vbat_hi_i,
  input  logic          vbat_pd_i,
  input  logic          temp_hot_i,
  input  logic          temp_cut_i,
  input  logic [1:0]    mode_i,
  input  logic          inhibit_i,
  input  logic          vterm_i,
  input  logic [TW-1:0] elapsed_i,
  input  logic [TW-1:0] limit_i,
  input  logic [TW-1:0] holdoff_len_i,
  input  logic          topoff_en_i,
  output logic [1:0]    mode_o,
  output logic          timer_run_o,
  output logic          timer_clr_o,
  output phase_e        phase_o,
  output logic          holdoff_o,
  output logic          det_rst_o,
  output cause_e        term_o
);
  localparam int DW = (START_DLY_TICKS > 0) ? $clog2(START_DLY_TICKS + 1) : 1;
  localparam logic [DW-1:0] DLY_LOAD = DW'(START_DLY_TICKS);

  phase_e        state_q, state_d;
  cause_e        term_q, term_d;
  logic [1:0]    mode_q, mode_d;
  logic [DW-1:0] dly_q, dly_d;
  logic          hi_q, hi_fall, expired, hold, clr, det_q;

  assign hi_fall = hi_q && !vbat_hi_i;
  assign expired = (elapsed_i >= limit_i);
  assign hold    = (state_q == PH_FAST) && (elapsed_i < holdoff_len_i);

  always_comb begin
    state_d = state_q;
    term_d  = term_q;
    mode_d  = mode_q;
    dly_d   = dly_q;
    clr     = 1'b0;
    if (vbat_pd_i) begin
      state_d = PH_LOWPWR;
    end else if (state_q == PH_LOWPWR) begin
      state_d = PH_TRICKLE;
    end else if (hi_fall) begin
      state_d = PH_PEND;
      term_d  = CAUSE_NONE;
      dly_d   = DLY_LOAD;
    end else begin
      unique case (state_q)
        PH_PEND: begin
          if (dly_q != '0) begin
            if (tick_i) dly_d = dly_q - 1'b1;
          end else if (!vbat_lo_i && !vbat_hi_i && !temp_hot_i) begin
            state_d = PH_FAST;
            mode_d  = mode_i;
            clr     = 1'b1;
          end else begin
            state_d = PH_TRICKLE;
          end
        end
        PH_FAST: begin
          if (temp_cut_i) begin
            state_d = PH_TRICKLE; term_d = CAUSE_TEMP;
          end else if (!inhibit_i) begin
            if (vbat_hi_i) begin
              state_d = PH_TRICKLE; term_d = CAUSE_VMAX;
            end else if ((vterm_i && !hold) || expired) begin
              term_d  = (vterm_i && !hold) ? CAUSE_SLOPE : CAUSE_TIME;
              state_d = topoff_en_i ? PH_TOP : PH_TRICKLE;
              clr     = topoff_en_i;
            end
          end
        end
        PH_TOP: begin
          if (temp_cut_i) begin
            state_d = PH_TRICKLE; term_d = CAUSE_TEMP;
          end else if (!inhibit_i) begin
            if (vbat_hi_i) begin
              state_d = PH_TRICKLE; term_d = CAUSE_VMAX;
            end else if (expired) begin
              state_d = PH_TRICKLE; term_d = CAUSE_TIME;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= PH_PEND;
      term_q  <= CAUSE_NONE;
      mode_q  <= MODE_MID;
      dly_q   <= '0;
      hi_q    <= 1'b0;
      det_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      term_q  <= term_d;
      mode_q  <= mode_d;
      dly_q   <= dly_d;
      hi_q    <= vbat_hi_i;
      det_q   <= clr && (state_d == PH_FAST);
    end
  end

  assign phase_o     = state_q;
  assign term_o      = term_q;
  assign mode_o      = mode_q;
  assign holdoff_o   = hold;
  assign det_rst_o   = det_q;
  assign timer_clr_o = clr;
  assign timer_run_o = ((state_q == PH_FAST) || (state_q == PH_TOP)) && !inhibit_i;

  // R2: fast charge entered only from valid conditions
  assert_fast_entry_valid_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == PH_FAST && $past(state_q) == PH_PEND)
      |-> $past(!vbat_lo_i && !vbat_hi_i && !temp_hot_i));
  // R7: top-off only follows fast charge with top-off enabled
  assert_topoff_mode_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == PH_TOP && $past(state_q) == PH_FAST) |-> topoff_en_i);
  // R11: power-down flag forces low-power
  assert_lowpwr_entry_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vbat_pd_i |=> (state_q == PH_LOWPWR));
  // R9: inhibit freezes the charging phase
  assert_inhibit_freeze_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inhibit_i && (state_q == PH_FAST || state_q == PH_TOP) && !temp_cut_i
     && !vbat_pd_i && !hi_fall) |=> $stable(state_q));
  // R6: slope events do not end fast charge during hold-off
  assert_holdoff_ignores_slope_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hold && !temp_cut_i && !vbat_hi_i && !vbat_pd_i && !hi_fall && !expired)
      |=> (state_q == PH_FAST));
endmodule

// File: rtl/charge_seq.sv
module charge_seq
  import charge_seq_pkg::*;
#(
  parameter int TICKS_PER_SEC   = 1000,
  parameter int SEC_PER_MIN     = 60,
  parameter int START_DLY_TICKS = 500,
  parameter int ALT_MID_LIMIT   = 0
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_ms_i,
  input  logic       vbat_lo_i,
  input  logic       vbat_hi_i,
  input  logic       vbat_pd_i,
  input  logic       temp_hot_i,
  input  logic       temp_cut_i,
  input  logic [1:0] mode_i,
  input  logic       inhibit_i,
  input  logic       vterm_i,
  output logic [2:0] phase_o,
  output logic       led_en_o,
  output logic       holdoff_o,
  output logic       det_rst_o,
  output logic       slope_neg_o,
  output logic [2:0] term_o
);
  localparam int TW = $clog2(200 * SEC_PER_MIN + 1);

  logic [TW-1:0] elapsed, limit_s, holdoff_s;
  logic [1:0]    mode_q;
  logic          topoff_en, run, clr;
  phase_e        phase;
  cause_e        term;

  charge_seq_sec_timer #(.TICKS_PER_SEC(TICKS_PER_SEC), .TW(TW)) i_timer (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_ms_i),
    .run_i(run), .clr_i(clr), .elapsed_o(elapsed)
  );

  charge_seq_mode_cfg #(.SEC_PER_MIN(SEC_PER_MIN), .ALT_MID_LIMIT(ALT_MID_LIMIT), .TW(TW)) i_cfg (
    .mode_i(mode_q), .limit_o(limit_s), .holdoff_o(holdoff_s),
    .topoff_en_o(topoff_en), .slope_neg_o(slope_neg_o)
  );

  charge_seq_fsm #(.START_DLY_TICKS(START_DLY_TICKS), .TW(TW)) i_fsm (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_ms_i),
    .vbat_lo_i(vbat_lo_i), .vbat_hi_i(vbat_hi_i), .vbat_pd_i(vbat_pd_i),
    .temp_hot_i(temp_hot_i), .temp_cut_i(temp_cut_i), .mode_i(mode_i),
    .inhibit_i(inhibit_i), .vterm_i(vterm_i), .elapsed_i(elapsed),
    .limit_i(limit_s), .holdoff_len_i(holdoff_s), .topoff_en_i(topoff_en),
    .mode_o(mode_q), .timer_run_o(run), .timer_clr_o(clr), .phase_o(phase),
    .holdoff_o(holdoff_o), .det_rst_o(det_rst_o), .term_o(term)
  );

  assign phase_o  = phase;
  assign term_o   = term;
  assign led_en_o = (phase == PH_FAST);

  // R8: det reset pulse only in a fast-charge cycle
  assert_det_rst_in_fast_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    det_rst_o |-> (led_en_o && !$past(led_en_o)));
endmodule

// File: tb/test_charge_seq.sv
module test_charge_seq;
  localparam int TPS = 1;
  localparam int SPM = 4;
  localparam int DLY = 6;
  localparam int L_LOW = 80 * SPM;
  localparam int L_HIGH = 40 * SPM;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic tick_ms_i = 1'b1;
  logic vbat_lo_i = 0, vbat_hi_i = 0, vbat_pd_i = 0, temp_hot_i = 0, temp_cut_i = 0;
  logic [1:0] mode_i = 2'd0;
  logic inhibit_i = 0, vterm_i = 0;
  logic [2:0] phase_o, term_o;
  logic led_en_o, holdoff_o, det_rst_o, slope_neg_o;
  int checks = 0, errors = 0;

  always #5 clk_i = ~clk_i;

  charge_seq #(.TICKS_PER_SEC(TPS), .SEC_PER_MIN(SPM), .START_DLY_TICKS(DLY),
               .ALT_MID_LIMIT(0)) i_charge_seq (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_ms_i(tick_ms_i),
    .vbat_lo_i(vbat_lo_i), .vbat_hi_i(vbat_hi_i), .vbat_pd_i(vbat_pd_i),
    .temp_hot_i(temp_hot_i), .temp_cut_i(temp_cut_i), .mode_i(mode_i),
    .inhibit_i(inhibit_i), .vterm_i(vterm_i), .phase_o(phase_o),
    .led_en_o(led_en_o), .holdoff_o(holdoff_o), .det_rst_o(det_rst_o),
    .slope_neg_o(slope_neg_o), .term_o(term_o)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic restart(input logic [1:0] m, input logic lo, input logic hot);
    @(negedge clk_i);
    rst_ni = 0;
    vbat_lo_i = lo; vbat_hi_i = 0; vbat_pd_i = 0; temp_hot_i = hot; temp_cut_i = 0;
    inhibit_i = 0; vterm_i = 0; mode_i = m;
    cyc(1);
    rst_ni = 1;
    cyc(1);
  endtask

  task automatic t_reset;
    rst_ni = 0;
    cyc(2);
    chk("R1", "phase", phase_o, 0);
    chk("R1", "led", led_en_o, 0);
    chk("R1", "holdoff", holdoff_o, 0);
    chk("R1", "det_rst", det_rst_o, 0);
    chk("R1", "term", term_o, 0);
    rst_ni = 1;
    cyc(1);
    chk("R2", "phase fast", phase_o, 1);
    chk("R8", "led fast", led_en_o, 1);
    chk("R8", "det_rst pulse", det_rst_o, 1);
    cyc(1);
    chk("R8", "det_rst ends", det_rst_o, 0);
  endtask

  task automatic t_invalid;
    restart(2'd0, 1'b1, 1'b0);
    chk("R2", "low voltage -> trickle", phase_o, 3);
    chk("R8", "led off trickle", led_en_o, 0);
    restart(2'd0, 1'b0, 1'b1);
    chk("R2", "hot -> trickle", phase_o, 3);
  endtask

  task automatic t_holdoff(input logic [1:0] m, input int h, input int neg);
    restart(m, 0, 0);
    chk("R4", "slope select", slope_neg_o, neg);
    cyc(h - 1);
    chk("R6", "holdoff active", holdoff_o, 1);
    cyc(1);
    chk("R4", "holdoff length", holdoff_o, 0);
  endtask

  task automatic t_slope_holdoff;
    restart(2'd2, 0, 0);
    cyc(75 - 1);
    vterm_i = 1;
    cyc(1);
    chk("R6", "slope in holdoff ignored", phase_o, 1);
    cyc(1);
    chk("R5", "slope ends fast", phase_o, 3);
    chk("R5", "cause slope", term_o, 3);
    vterm_i = 0;
  endtask

  task automatic t_vmax_insert;
    restart(2'd0, 0, 0);
    cyc(3);
    vbat_hi_i = 1;
    cyc(1);
    chk("R6", "vmax acts in holdoff", phase_o, 3);
    chk("R7", "vmax cause no topoff", term_o, 2);
    vbat_hi_i = 0;
    cyc(1);
    chk("R3", "insertion -> pending", phase_o, 0);
    chk("R3", "cause cleared", term_o, 0);
    cyc(DLY);
    chk("R3", "still pending in delay", phase_o, 0);
    cyc(1);
    chk("R3", "fast after delay", phase_o, 1);
    chk("R8", "det_rst after insertion", det_rst_o, 1);
  endtask

  task automatic t_priority;
    restart(2'd0, 0, 0);
    cyc(160);
    temp_cut_i = 1; vbat_hi_i = 1; vterm_i = 1;
    cyc(1);
    chk("R5", "temp wins", term_o, 1);
    chk("R5", "temp -> trickle", phase_o, 3);
    restart(2'd0, 0, 0);
    cyc(160);
    vbat_hi_i = 1; vterm_i = 1;
    cyc(1);
    chk("R5", "vmax over slope", term_o, 2);
    restart(2'd0, 0, 0);
    cyc(L_LOW);
    vterm_i = 1;
    cyc(1);
    chk("R5", "slope over timer", term_o, 3);
    chk("R7", "slope -> topoff", phase_o, 2);
    vterm_i = 0;
  endtask

  task automatic t_topoff;
    restart(2'd0, 0, 0);
    cyc(L_LOW);
    chk("R10", "fast before limit", phase_o, 1);
    cyc(1);
    chk("R7", "timer -> topoff", phase_o, 2);
    chk("R10", "cause timer", term_o, 4);
    chk("R8", "led off topoff", led_en_o, 0);
    vterm_i = 1;
    cyc(L_LOW);
    chk("R7", "topoff ignores slope", phase_o, 2);
    cyc(1);
    chk("R10", "topoff timer rearmed", phase_o, 3);
    vterm_i = 0;
    cyc(400);
    chk("R10", "trickle no limit", phase_o, 3);
  endtask

  task automatic t_inhibit;
    restart(2'd2, 0, 0);
    cyc(10);
    inhibit_i = 1;
    cyc(20);
    chk("R9", "fast frozen", phase_o, 1);
    chk("R9", "led frozen", led_en_o, 1);
    inhibit_i = 0;
    cyc(L_HIGH - 10);
    chk("R9", "timer held during inhibit", phase_o, 1);
    cyc(1);
    chk("R9", "expiry after resume", phase_o, 3);
    chk("R10", "cause timer", term_o, 4);
    restart(2'd0, 0, 0);
    inhibit_i = 1;
    vbat_hi_i = 1;
    cyc(3);
    chk("R9", "vmax suspended", phase_o, 1);
    temp_cut_i = 1;
    cyc(1);
    chk("R9", "temp acts under inhibit", phase_o, 3);
    chk("R9", "temp cause", term_o, 1);
    inhibit_i = 0; temp_cut_i = 0;
  endtask

  task automatic t_lowpwr;
    restart(2'd1, 0, 0);
    cyc(5);
    vbat_pd_i = 1; vbat_hi_i = 1;
    cyc(1);
    chk("R11", "lowpower", phase_o, 4);
    chk("R11", "led off", led_en_o, 0);
    cyc(5);
    chk("R11", "stays lowpower", phase_o, 4);
    vbat_pd_i = 0;
    cyc(1);
    chk("R11", "exit to trickle", phase_o, 3);
  endtask

  initial begin
    #(200000 * 10);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_invalid();
    t_holdoff(2'd0, 150, 0);
    t_holdoff(2'd1, 300, 0);
    t_holdoff(2'd2, 75, 1);
    t_holdoff(2'd3, 300, 0);
    t_slope_holdoff();
    t_vmax_insert();
    t_priority();
    t_topoff();
    t_inhibit();
    t_lowpwr();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule